// File: doc/BRIEF.md
# Display RAM Write Sequencer

This block sits behind a serial command decoder in a dot-matrix display controller. The decoder hands it one byte at a time. Each byte comes with a flag that says whether it is a command byte, and with a decoded target that selects one of three display memories. A command byte picks the memory and loads the start address. Each data byte that follows in the same chip-select frame is written at the current position, and the position then advances on its own.

There are three memories, all held as register arrays inside the block:
- a 16-entry table of 8-bit character codes, one per display digit;
- a 16-entry table of 2-bit symbol flags, one per digit;
- an 8-entry table of user glyphs. Each glyph is 35 dots, sent as five column bytes of seven dots each.

The glyph table advances its address only after all five column bytes of an entry have arrived. Each column byte is written as soon as it arrives, so a glyph that is only partly sent still updates the columns that did arrive. Each memory has its own combinational read port for the display scanner.

Top module: `dram_write_seq`

## Requirements
- R1: After synchronous reset every entry of all three memories reads zero and the block is idle: data bytes change nothing until a command byte selects a memory.
- R2: A command byte with target 1 (character) loads the address from byte bits 3..0. Each later data byte is stored whole at the current address, and the address then increments by one.
- R3: The character and symbol address is 4 bits and wraps from 15 to 0, so the seventeenth data byte after a command at address 0 overwrites entry 0.
- R4: Target 2 (symbol) addresses the same way as R2 and R3, but stores only data bits 1..0.
- R5: Target 3 (glyph) loads the glyph address from byte bits 2..0; bit 3 and the bits above it are ignored.
- R6: A glyph entry is written by five data bytes, for columns k = 0..4 in order. Bit j (j = 0..6) of the column-k byte becomes dot k+5j of the 35-bit entry (dot n is bit n of the read data), and bit 7 is ignored.
- R7: After the column-4 byte, the column counter returns to 0 and the glyph address increments, wrapping from 7 to 0.
- R8: A frame-end pulse makes the block idle. A data or command byte in the same cycle as frame-end is ignored, and later data bytes are ignored until the next command.
- R9: A new command byte in the middle of a stream replaces the target and address at once and restarts the glyph column at 0.
- R10: A glyph stream cut short leaves the columns already received updated and the other columns of that entry unchanged.
- R11: A command byte with target 0 makes the block idle, so the data bytes that follow write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | Single-cycle pulse at chip-select release |
| byte_valid | input | 1 | A byte is presented this cycle |
| byte_is_cmd | input | 1 | The presented byte is a command byte |
| cmd_target | input | 2 | Decoded target: 0 none, 1 character, 2 symbol, 3 glyph |
| byte_data | input | 8 | Byte payload |
| char_raddr | input | 4 | Character table read address |
| char_rdata | output | 8 | Character table read data |
| sym_raddr | input | 4 | Symbol table read address |
| sym_rdata | output | 2 | Symbol table read data |
| glyph_raddr | input | 3 | Glyph table read address |
| glyph_rdata | output | 35 | Glyph entry, dot n at bit n |

## Verification
The bench builds the block with its default parameters: 16 digit entries, 8 glyph entries, and glyphs of 5 columns by 7 rows. With these values the 4-bit digit wrap, the 3-bit glyph wrap and the last-column rollover can all be reached in a few dozen bytes, so the directed cases cover every boundary. The random phase then mixes frame ends, target changes and frame ends that land in the same cycle as a byte. After each of these it scans all 40 entries against a bench model.

// File: rtl/dram_pkg.sv
package dram_pkg;

    // Decoded write target delivered alongside each command byte.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_CHAR  = 2'd1,
        TGT_SYM   = 2'd2,
        TGT_GLYPH = 2'd3
    } tgt_e;

    // Single-cycle byte event seen by the sequencer.
    typedef struct packed {
        logic       is_cmd;
        logic       is_data;
        tgt_e       target;
    } byte_evt_t;

    // Classify an incoming byte; frame end suppresses any byte in the same cycle.
    function automatic byte_evt_t classify(input logic valid, input logic is_cmd,
                                           input logic fend, input logic [1:0] tgt);
        byte_evt_t e;
        e.is_cmd  = valid & is_cmd & ~fend;
        e.is_data = valid & ~is_cmd & ~fend;
        e.target  = tgt_e'(tgt);
        return e;
    endfunction

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_pkg::*;
#(
    parameter int unsigned AW   = 4,
    parameter int unsigned PAW  = 3,
    parameter int unsigned COLS = 5,
    localparam int unsigned COLW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_end,
    input  logic            byte_valid,
    input  logic            byte_is_cmd,
    input  logic [1:0]      cmd_target,
    input  logic [AW-1:0]   cmd_addr,
    output logic            char_we,
    output logic            sym_we,
    output logic            glyph_we,
    output logic [AW-1:0]   wr_addr,
    output logic [PAW-1:0]  glyph_addr,
    output logic [COLW-1:0] glyph_col
);

    localparam logic [COLW-1:0] LAST_COL = COLW'(COLS - 1);

    tgt_e            mode_q;
    logic [AW-1:0]   addr_q;
    logic [PAW-1:0]  gaddr_q;
    logic [COLW-1:0] col_q;
    byte_evt_t       evt;

    assign evt = classify(byte_valid, byte_is_cmd, frame_end, cmd_target);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= TGT_NONE;
            addr_q  <= '0;
            gaddr_q <= '0;
            col_q   <= '0;
        end else if (frame_end) begin
            mode_q  <= TGT_NONE;
        end else if (evt.is_cmd) begin
            mode_q  <= evt.target;
            addr_q  <= cmd_addr;
            gaddr_q <= cmd_addr[PAW-1:0];
            col_q   <= '0;
        end else if (evt.is_data) begin
            unique case (mode_q)
                TGT_CHAR, TGT_SYM: addr_q <= addr_q + 1'b1;
                TGT_GLYPH: begin
                    if (col_q == LAST_COL) begin
                        col_q   <= '0;
                        gaddr_q <= gaddr_q + 1'b1;
                    end else begin
                        col_q   <= col_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign char_we    = evt.is_data && (mode_q == TGT_CHAR);
    assign sym_we     = evt.is_data && (mode_q == TGT_SYM);
    assign glyph_we   = evt.is_data && (mode_q == TGT_GLYPH);
    assign wr_addr    = addr_q;
    assign glyph_addr = gaddr_q;
    assign glyph_col  = col_q;

    p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({char_we, sym_we, glyph_we}));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (char_we || sym_we) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

    p_col_range_r6: assert property (@(posedge clk) disable iff (rst)
        col_q <= LAST_COL);

    p_glyph_roll_r7: assert property (@(posedge clk) disable iff (rst)
        (glyph_we && col_q == LAST_COL) |=>
            (col_q == '0 && gaddr_q == PAW'($past(gaddr_q) + 1'b1)));

    p_frame_idle_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (mode_q == TGT_NONE));

    p_cmd_restart_r9: assert property (@(posedge clk) disable iff (rst)
        evt.is_cmd |=> (col_q == '0 && addr_q == $past(cmd_addr)));

endmodule

// File: rtl/dram_word_mem.sv
module dram_word_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    p_word_store_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dram_glyph_mem.sv
module dram_glyph_mem #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned COLS  = 5,
    parameter int unsigned ROWS  = 7,
    localparam int unsigned PAW  = $clog2(DEPTH),
    localparam int unsigned COLW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int unsigned DOTS = COLS * ROWS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [PAW-1:0]  waddr,
    input  logic [COLW-1:0] col,
    input  logic [ROWS-1:0] wdata,
    input  logic [PAW-1:0]  raddr,
    output logic [DOTS-1:0] rdata
);

    logic [DOTS-1:0] mem_q [DEPTH];
    logic [DOTS-1:0] col_mask;
    logic [DOTS-1:0] col_bits;

    // Column k, row j lands on dot k + COLS*j.
    always_comb begin
        col_mask = '0;
        col_bits = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                if (col == COLW'(c)) begin
                    col_mask[c + COLS*r] = 1'b1;
                    col_bits[c + COLS*r] = wdata[r];
                end
            end
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[e] <= '0;
            end else if (we && waddr == PAW'(e)) begin
                mem_q[e] <= (mem_q[e] & ~col_mask) | col_bits;
            end
        end
    end

    assign rdata = mem_q[raddr];

    p_keep_other_cols_r10: assert property (@(posedge clk) disable iff (rst)
        we |=> (((mem_q[$past(waddr)] ^ $past(mem_q[waddr])) & ~$past(col_mask)) == '0));

    p_col_written_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> ((mem_q[$past(waddr)] & $past(col_mask)) == $past(col_bits)));

endmodule

// File: rtl/dram_write_seq.sv
module dram_write_seq #(
    parameter int unsigned CHAR_DEPTH  = 16,
    parameter int unsigned GLYPH_DEPTH = 8,
    parameter int unsigned COLS        = 5,
    parameter int unsigned ROWS        = 7,
    parameter int unsigned SYM_W       = 2,
    localparam int unsigned AW   = $clog2(CHAR_DEPTH),
    localparam int unsigned PAW  = $clog2(GLYPH_DEPTH),
    localparam int unsigned COLW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int unsigned DOTS = COLS * ROWS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_end,
    input  logic            byte_valid,
    input  logic            byte_is_cmd,
    input  logic [1:0]      cmd_target,
    input  logic [7:0]      byte_data,
    input  logic [AW-1:0]   char_raddr,
    output logic [7:0]      char_rdata,
    input  logic [AW-1:0]   sym_raddr,
    output logic [SYM_W-1:0] sym_rdata,
    input  logic [PAW-1:0]  glyph_raddr,
    output logic [DOTS-1:0] glyph_rdata
);

    logic            char_we, sym_we, glyph_we;
    logic [AW-1:0]   wr_addr;
    logic [PAW-1:0]  glyph_addr;
    logic [COLW-1:0] glyph_col;

    dram_seq_ctrl #(.AW(AW), .PAW(PAW), .COLS(COLS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .byte_valid (byte_valid),
        .byte_is_cmd(byte_is_cmd),
        .cmd_target (cmd_target),
        .cmd_addr   (byte_data[AW-1:0]),
        .char_we    (char_we),
        .sym_we     (sym_we),
        .glyph_we   (glyph_we),
        .wr_addr    (wr_addr),
        .glyph_addr (glyph_addr),
        .glyph_col  (glyph_col)
    );

    dram_word_mem #(.DEPTH(CHAR_DEPTH), .W(8)) u_char (
        .clk  (clk),
        .rst  (rst),
        .we   (char_we),
        .waddr(wr_addr),
        .wdata(byte_data),
        .raddr(char_raddr),
        .rdata(char_rdata)
    );

    dram_word_mem #(.DEPTH(CHAR_DEPTH), .W(SYM_W)) u_sym (
        .clk  (clk),
        .rst  (rst),
        .we   (sym_we),
        .waddr(wr_addr),
        .wdata(byte_data[SYM_W-1:0]),
        .raddr(sym_raddr),
        .rdata(sym_rdata)
    );

    dram_glyph_mem #(.DEPTH(GLYPH_DEPTH), .COLS(COLS), .ROWS(ROWS)) u_glyph (
        .clk  (clk),
        .rst  (rst),
        .we   (glyph_we),
        .waddr(glyph_addr),
        .col  (glyph_col),
        .wdata(byte_data[ROWS-1:0]),
        .raddr(glyph_raddr),
        .rdata(glyph_rdata)
    );

endmodule

// File: tb/dram_write_seq_test.sv
module dram_write_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_end, byte_valid, byte_is_cmd;
    logic [1:0]  cmd_target;
    logic [7:0]  byte_data;
    logic [3:0]  char_raddr, sym_raddr;
    logic [2:0]  glyph_raddr;
    logic [7:0]  char_rdata;
    logic [1:0]  sym_rdata;
    logic [34:0] glyph_rdata;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Bench model, built from the requirements
    logic [7:0]  m_char  [16];
    logic [1:0]  m_sym   [16];
    logic [34:0] m_glyph [8];
    int          m_mode, m_addr, m_gaddr, m_col;

    always #2.5 clk = ~clk;

    dram_write_seq uut (
        .clk(clk), .rst(rst), .frame_end(frame_end), .byte_valid(byte_valid),
        .byte_is_cmd(byte_is_cmd), .cmd_target(cmd_target), .byte_data(byte_data),
        .char_raddr(char_raddr), .char_rdata(char_rdata),
        .sym_raddr(sym_raddr), .sym_rdata(sym_rdata),
        .glyph_raddr(glyph_raddr), .glyph_rdata(glyph_rdata)
    );

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) begin m_char[i] = '0; m_sym[i] = '0; end
        for (int i = 0; i < 8; i++) m_glyph[i] = '0;
        m_mode = 0; m_addr = 0; m_gaddr = 0; m_col = 0;
    endfunction

    function automatic void model_step(bit v, bit c, bit [1:0] t, bit [7:0] d, bit fe);
        if (fe) m_mode = 0;
        else if (v && c) begin
            m_mode = t; m_addr = d[3:0]; m_gaddr = d[2:0]; m_col = 0;   // R2 R5 R9 R11
        end else if (v) begin
            if (m_mode == 1) begin m_char[m_addr] = d; m_addr = (m_addr + 1) % 16; end
            else if (m_mode == 2) begin m_sym[m_addr] = d[1:0]; m_addr = (m_addr + 1) % 16; end
            else if (m_mode == 3) begin
                for (int j = 0; j < 7; j++) m_glyph[m_gaddr][m_col + 5*j] = d[j];  // R6
                if (m_col == 4) begin m_col = 0; m_gaddr = (m_gaddr + 1) % 8; end  // R7
                else m_col++;
            end
        end
    endfunction

    task automatic drive(bit v, bit c, bit [1:0] t, bit [7:0] d, bit fe);
        byte_valid = v; byte_is_cmd = c; cmd_target = t; byte_data = d; frame_end = fe;
        @(negedge clk);
        byte_valid = 0; byte_is_cmd = 0; cmd_target = 0; byte_data = 0; frame_end = 0;
        model_step(v, c, t, d, fe);
    endtask

    task automatic cmd(bit [1:0] t, bit [7:0] d);   drive(1, 1, t, d, 0); endtask
    task automatic dat(bit [7:0] d);                drive(1, 0, 0, d, 0); endtask
    task automatic close();                         drive(0, 0, 0, 0, 1); endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 16; i++) begin
            char_raddr = 4'(i); sym_raddr = 4'(i); glyph_raddr = 3'(i % 8);
            #1;
            vectors++;
            if (char_rdata !== m_char[i]) begin
                fails++;
                $display("FAIL %s char[%0d]: got %h expected %h", tag, i, char_rdata, m_char[i]);
            end
            vectors++;
            if (sym_rdata !== m_sym[i]) begin
                fails++;
                $display("FAIL %s sym[%0d]: got %h expected %h", tag, i, sym_rdata, m_sym[i]);
            end
            if (i < 8) begin
                vectors++;
                if (glyph_rdata !== m_glyph[i]) begin
                    fails++;
                    $display("FAIL %s glyph[%0d]: got %h expected %h", tag, i, glyph_rdata, m_glyph[i]);
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; frame_end = 0; byte_valid = 0; byte_is_cmd = 0; cmd_target = 0;
        byte_data = 0; char_raddr = 0; sym_raddr = 0; glyph_raddr = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_all("R1 reset");
        dat(8'h5A); dat(8'hC3);
        check_all("R1 idle after reset");

        // R2 and R3: start at D, run across the wrap
        cmd(2'd1, 8'hFD);
        dat(8'h11); dat(8'h22); dat(8'h33); dat(8'h44);
        check_all("R2 R3 char start D wrap");
        cmd(2'd1, 8'h00);
        for (int i = 0; i < 17; i++) dat(8'(8'h80 + i));
        check_all("R3 seventeenth byte overwrites 0");

        // R4: symbol keeps two low bits
        cmd(2'd2, 8'h03);
        dat(8'hFF); dat(8'hFE); dat(8'h7D);
        check_all("R4 symbol low bits");

        // R5 R6 R7: address from bits 2..0, bit 7 ignored, rollover and wrap
        cmd(2'd3, 8'h0E);
        for (int i = 0; i < 15; i++) dat(8'(8'h80 | (i * 37)));
        check_all("R5 R6 R7 glyph rollover wrap");

        // R10 and R8: partial glyph then frame end, later bytes ignored
        cmd(2'd3, 8'h02);
        dat(8'h7F); dat(8'h55);
        close();
        dat(8'h2A); dat(8'h01);
        check_all("R10 R8 partial glyph and close");

        // R8: byte coincident with frame end is ignored
        cmd(2'd1, 8'h04);
        drive(1, 0, 0, 8'hEE, 1);
        dat(8'h99);
        check_all("R8 byte with frame end");

        // R9: new command mid glyph restarts column
        cmd(2'd3, 8'h04);
        dat(8'h01); dat(8'h02); dat(8'h03);
        cmd(2'd3, 8'h05);
        dat(8'h7F);
        check_all("R9 command mid stream");

        // R11: target none then data
        cmd(2'd2, 8'h00);
        cmd(2'd0, 8'h07);
        dat(8'h03); dat(8'h02);
        check_all("R11 target none");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 24);
            if (r == 0) close();
            else if (r == 1) drive(1, 0, 0, 8'($urandom), 1);
            else if (r < 5) cmd(2'($urandom), 8'($urandom));
            else dat(8'($urandom));
            if (n % 30 == 29) check_all("R2 R4 R6 R7 R8 random");
        end
        check_all("R2 R6 random final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule